// File: doc/BRIEF.md
# Debug Control Register with Processor Access Handshake

This block holds the 32-bit debug control word that a debug probe reads and writes through a scan chain. It also runs the handshake by which the processor hands memory accesses in the debug segment to the probe. The processor posts a request with its direction, size and address. The request is accepted only while no access is outstanding and the probe has enabled servicing. It then stays pending until the probe completes it.

The probe completes an access by scanning in a control word with the pending flag cleared. It can do the same through a one-bit completion flag in the fast-data chain. In both chains a completion counts only when the value captured at the start of that same scan showed the access as pending. This stops a scan that began before the request arrived from retiring the request by accident.

The same word reports status: that a reset has occurred, debug mode, low-power state and a stopped bus clock. It also drives command outputs: the processor reset request, the peripheral reset request, the debug-interrupt request, probe servicing enable and the debug-vector location. The scan interface is a set of single-clock strobes (select, capture, shift, update) synchronous to the block clock. The processor bus itself lies outside the block.

Top module: `dbg_ctl_reg`

## Requirements
- R1: After reset the reset-occurred bit (31) reads 1. All command outputs are 0, no access is pending, and the first captured control word is 0x8000_0000 while the status inputs are low.
- R2: A capture strobe loads the read word into the shift register. Each shift strobe moves `scan_tdi` in at bit 31 and shifts toward bit 0, and `scan_tdo` presents bit 0. So the word is read and written least significant bit first. Commands take effect only on the update strobe.
- R3: A processor request is accepted, and `req_ready` is high, only while no access is pending and probe servicing (bit 15) is 1. A request offered at any other time leaves the latched access unchanged.
- R4: While an access is pending, bit 18 reads 1 and bit 19 gives its direction (1 = store, 0 = load or fetch). Bits 30:29 give its size (0 byte, 1 halfword, 2 word, 3 triple), and `acc_addr`, `acc_write` and `acc_size` hold the request. With no access pending, bits 30:18 of these fields read 0.
- R5: An update whose shifted-in bit 18 is 0 completes the access when the capture of that scan had bit 18 set. Completion clears the pending state and pulses `acc_done` for exactly one cycle. Writing bit 18 as 1 leaves the access pending.
- R6: If the capture of a scan had bit 18 clear, writing bit 18 as 0 completes nothing, even when a request was accepted during the shift.
- R7: Bit 31 is set by reset and by a `sys_reset_event` pulse. Writing it 0 clears it and writing it 1 has no effect. A reset event in the same cycle as a clearing write leaves it set.
- R8: Bit 16 drives `proc_rst_req` and bit 20 drives `per_rst_req`. Both take the written value at update and read back as their current state.
- R9: Writing bit 12 as 1 raises `dbg_int_req`. Writing it 0 has no effect. It reads 1 while pending and is cleared by `dbg_int_ack`.
- R10: Bit 15 drives `probe_en` and bit 14 drives `probe_trap`. Both read back as written.
- R11: Bits 3, 22 and 21 read `cpu_debug_mode`, `cpu_low_power` and `cpu_clk_stopped` as sampled at capture. Writes to them have no effect.
- R12: All bits not named above read 0 and ignore writes.
- R13: In the fast-data chain the single flag captures 1 when an access is pending (success) and 0 otherwise (failure). An update shifting in 0 completes the access under the same captured-flag rule as R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Processor offers an access |
| req_write | input | 1 | Offered access is a store |
| req_size | input | 2 | Offered access size code |
| req_addr | input | ADDR_W | Offered access address |
| req_ready | output | 1 | Block can accept an access this cycle |
| acc_pending | output | 1 | An accepted access awaits completion |
| acc_write | output | 1 | Direction of the pending access |
| acc_size | output | 2 | Size of the pending access |
| acc_addr | output | ADDR_W | Address of the pending access |
| acc_done | output | 1 | One-cycle pulse when the probe completes the access |
| cpu_debug_mode | input | 1 | Processor is in debug mode |
| cpu_low_power | input | 1 | Processor is in low-power state |
| cpu_clk_stopped | input | 1 | Internal bus clock is stopped |
| sys_reset_event | input | 1 | Pulse marking a system reset |
| dbg_int_ack | input | 1 | Processor took the debug interrupt |
| proc_rst_req | output | 1 | Processor reset request |
| per_rst_req | output | 1 | Peripheral reset request |
| dbg_int_req | output | 1 | Debug interrupt request |
| probe_en | output | 1 | Probe services processor accesses |
| probe_trap | output | 1 | Debug vector fetches from probe memory |
| scan_ctl_sel | input | 1 | Control chain is selected |
| scan_fd_sel | input | 1 | Fast-data flag chain is selected |
| scan_capture | input | 1 | Capture strobe |
| scan_shift | input | 1 | Shift strobe |
| scan_update | input | 1 | Update strobe |
| scan_tdi | input | 1 | Serial data in |
| scan_tdo | output | 1 | Serial data out of the selected chain |

## Verification
A wrong pending state shows at once at `req_ready` and `acc_pending`. The next scan shows it too: its capture reports bit 18 and the direction and size fields. A stale or missing captured flag shows only at the update that closes a scan, as a missing or spurious `acc_done` pulse in the cycle after that strobe. Errors in the command bits show on their output pins immediately after the update. They also come back in the very next captured word, so each write is checked once at the pin and once through the chain.

// File: rtl/dbg_ctl_pkg.sv
package dbg_ctl_pkg;
  localparam int CTRL_W    = 32;
  localparam int B_ROCC    = 31;
  localparam int B_SZ_HI   = 30;
  localparam int B_SZ_LO   = 29;
  localparam int B_LOWPWR  = 22;
  localparam int B_CLKSTOP = 21;
  localparam int B_PERRST  = 20;
  localparam int B_DIR     = 19;
  localparam int B_PEND    = 18;
  localparam int B_PRST    = 16;
  localparam int B_PROBE   = 15;
  localparam int B_TRAP    = 14;
  localparam int B_DINT    = 12;
  localparam int B_DBGMODE = 3;
  localparam int SIZE_W    = B_SZ_HI - B_SZ_LO + 1;

  typedef struct packed {
    logic lowpwr;
    logic clkstop;
    logic dbgmode;
  } cpu_stat_t;

  typedef struct packed {
    logic rocc;
    logic per_rst;
    logic proc_rst;
    logic probe_en;
    logic trap;
    logic dint;
  } cmd_state_t;
endpackage

// File: rtl/dbg_scan_stage.sv
module dbg_scan_stage #(
  parameter int W       = 32,
  parameter int CAP_BIT = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sel,
  input  logic         capture,
  input  logic         shift,
  input  logic         update,
  input  logic         tdi,
  input  logic [W-1:0] cap_val,
  output logic         tdo,
  output logic [W-1:0] upd_val,
  output logic         upd_stb,
  output logic         cap_flag
);
  logic [W-1:0] sr_q, sr_d;
  logic         flag_q, flag_d;
  logic         sr_en;

  always_comb begin
    sr_en  = sel && (capture || shift);
    sr_d   = sr_q;
    flag_d = flag_q;
    if (sel && capture) begin
      sr_d   = cap_val;
      flag_d = cap_val[CAP_BIT];
    end else if (sel && shift) begin
      sr_d[W-1] = tdi;
    end
  end

  generate
    if (W > 1) begin : g_wide
      logic [W-2:0] lower_d;
      always_comb begin
        lower_d = (sel && capture) ? cap_val[W-2:0] :
                  (sel && shift)   ? sr_q[W-1:1]    : sr_q[W-2:0];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sr_q <= '0;
        end else if (sr_en) begin
          sr_q <= {sr_d[W-1], lower_d};
        end
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sr_q <= '0;
        end else if (sr_en) begin
          sr_q <= sr_d;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (sel && capture) begin
      flag_q <= flag_d;
    end
  end

  assign tdo      = sr_q[0];
  assign upd_val  = sr_q;
  assign upd_stb  = sel && update;
  assign cap_flag = flag_q;

  p_shift_in_msb_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && shift && !capture) |=> (sr_q[W-1] == $past(tdi)));
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel && (capture || shift)) |=> $stable(sr_q));
endmodule

// File: rtl/dbg_acc_tracker.sv
module dbg_acc_tracker #(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              probe_en,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [SIZE_W-1:0] req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              ctl_upd,
  input  logic              ctl_cap_flag,
  input  logic              ctl_wr_flag,
  input  logic              fd_upd,
  input  logic              fd_cap_flag,
  input  logic              fd_wr_flag,
  output logic              req_ready,
  output logic              pending,
  output logic              acc_write,
  output logic [SIZE_W-1:0] acc_size,
  output logic [ADDR_W-1:0] acc_addr,
  output logic              acc_done
);
  logic              pend_q, pend_d;
  logic              wr_q;
  logic [SIZE_W-1:0] size_q;
  logic [ADDR_W-1:0] addr_q;
  logic              done_q, done_d;
  logic              accept, complete;

  always_comb begin
    req_ready = !pend_q && probe_en;
    accept    = req_valid && req_ready;
    complete  = pend_q &&
                ((ctl_upd && ctl_cap_flag && !ctl_wr_flag) ||
                 (fd_upd  && fd_cap_flag  && !fd_wr_flag));
    pend_d = pend_q;
    if (accept) begin
      pend_d = 1'b1;
    end else if (complete) begin
      pend_d = 1'b0;
    end
    done_d = complete;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= 1'b0;
      size_q <= '0;
      addr_q <= '0;
    end else if (accept) begin
      wr_q   <= req_write;
      size_q <= req_size;
      addr_q <= req_addr;
    end
  end

  assign pending   = pend_q;
  assign acc_write = wr_q;
  assign acc_size  = size_q;
  assign acc_addr  = addr_q;
  assign acc_done  = done_q;

  p_accept_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(probe_en && req_valid));
  p_hold_request_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && $past(pend_q)) |-> ($stable(addr_q) && $stable(size_q) && $stable(wr_q)));
  p_fall_pulses_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend_q) |-> done_q);
  p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  p_need_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(ctl_cap_flag || fd_cap_flag));
  p_fd_complete_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && fd_upd && fd_cap_flag && !fd_wr_flag) |=> (done_q && !pend_q));
endmodule

// File: rtl/dbg_cmd_bits.sv
module dbg_cmd_bits (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    upd,
  input  dbg_ctl_pkg::cmd_state_t wr,
  input  logic                    sys_reset_event,
  input  logic                    dbg_int_ack,
  output dbg_ctl_pkg::cmd_state_t state
);
  import dbg_ctl_pkg::*;

  cmd_state_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (upd) begin
      if (!wr.rocc) st_d.rocc = 1'b0;
      st_d.per_rst  = wr.per_rst;
      st_d.proc_rst = wr.proc_rst;
      st_d.probe_en = wr.probe_en;
      st_d.trap     = wr.trap;
    end
    if (dbg_int_ack) st_d.dint = 1'b0;
    if (upd && wr.dint) st_d.dint = 1'b1;
    if (sys_reset_event) st_d.rocc = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '{rocc: 1'b1, default: 1'b0};
    end else begin
      st_q <= st_d;
    end
  end

  assign state = st_q;

  p_reset_event_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sys_reset_event |=> state.rocc);
  p_rocc_write_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!state.rocc && !sys_reset_event) |=> !state.rocc);
  p_resets_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> (state.proc_rst == $past(wr.proc_rst) && state.per_rst == $past(wr.per_rst)));
  p_dint_raise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && wr.dint) |=> state.dint);
  p_probe_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> (state.probe_en == $past(wr.probe_en) && state.trap == $past(wr.trap)));
endmodule

// File: rtl/dbg_ctl_reg.sv
module dbg_ctl_reg #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              acc_pending,
  output logic              acc_write,
  output logic [1:0]        acc_size,
  output logic [ADDR_W-1:0] acc_addr,
  output logic              acc_done,
  input  logic              cpu_debug_mode,
  input  logic              cpu_low_power,
  input  logic              cpu_clk_stopped,
  input  logic              sys_reset_event,
  input  logic              dbg_int_ack,
  output logic              proc_rst_req,
  output logic              per_rst_req,
  output logic              dbg_int_req,
  output logic              probe_en,
  output logic              probe_trap,
  input  logic              scan_ctl_sel,
  input  logic              scan_fd_sel,
  input  logic              scan_capture,
  input  logic              scan_shift,
  input  logic              scan_update,
  input  logic              scan_tdi,
  output logic              scan_tdo
);
  import dbg_ctl_pkg::*;

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [CTRL_W-1:0] rd_word;
  logic [CTRL_W-1:0] ctl_upd_val;
  logic              ctl_upd, ctl_cap_flag, ctl_tdo;
  logic [0:0]        fd_upd_val;
  logic              fd_upd, fd_cap_flag, fd_tdo;
  cpu_stat_t         stat;
  cmd_state_t        cmd, cmd_wr;
  logic              pend;
  logic              unused_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  always_comb begin
    stat.lowpwr  = cpu_low_power;
    stat.clkstop = cpu_clk_stopped;
    stat.dbgmode = cpu_debug_mode;
  end

  always_comb begin
    rd_word                  = '0;
    rd_word[B_ROCC]          = cmd.rocc;
    rd_word[B_SZ_HI:B_SZ_LO] = pend ? acc_size : '0;
    rd_word[B_LOWPWR]        = stat.lowpwr;
    rd_word[B_CLKSTOP]       = stat.clkstop;
    rd_word[B_PERRST]        = cmd.per_rst;
    rd_word[B_DIR]           = pend && acc_write;
    rd_word[B_PEND]          = pend;
    rd_word[B_PRST]          = cmd.proc_rst;
    rd_word[B_PROBE]         = cmd.probe_en;
    rd_word[B_TRAP]          = cmd.trap;
    rd_word[B_DINT]          = cmd.dint;
    rd_word[B_DBGMODE]       = stat.dbgmode;
  end

  dbg_scan_stage #(.W(CTRL_W), .CAP_BIT(B_PEND)) u_ctl_chain (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .sel      (scan_ctl_sel),
    .capture  (scan_capture),
    .shift    (scan_shift),
    .update   (scan_update),
    .tdi      (scan_tdi),
    .cap_val  (rd_word),
    .tdo      (ctl_tdo),
    .upd_val  (ctl_upd_val),
    .upd_stb  (ctl_upd),
    .cap_flag (ctl_cap_flag)
  );

  dbg_scan_stage #(.W(1), .CAP_BIT(0)) u_fd_chain (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .sel      (scan_fd_sel),
    .capture  (scan_capture),
    .shift    (scan_shift),
    .update   (scan_update),
    .tdi      (scan_tdi),
    .cap_val  (pend),
    .tdo      (fd_tdo),
    .upd_val  (fd_upd_val),
    .upd_stb  (fd_upd),
    .cap_flag (fd_cap_flag)
  );

  always_comb begin
    cmd_wr.rocc     = ctl_upd_val[B_ROCC];
    cmd_wr.per_rst  = ctl_upd_val[B_PERRST];
    cmd_wr.proc_rst = ctl_upd_val[B_PRST];
    cmd_wr.probe_en = ctl_upd_val[B_PROBE];
    cmd_wr.trap     = ctl_upd_val[B_TRAP];
    cmd_wr.dint     = ctl_upd_val[B_DINT];
  end
  assign unused_bits = ^ctl_upd_val;

  dbg_cmd_bits u_cmd (
    .clk             (clk),
    .rst_n           (rst_int_n),
    .upd             (ctl_upd),
    .wr              (cmd_wr),
    .sys_reset_event (sys_reset_event),
    .dbg_int_ack     (dbg_int_ack),
    .state           (cmd)
  );

  dbg_acc_tracker #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_tracker (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .probe_en     (cmd.probe_en),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .req_size     (req_size),
    .req_addr     (req_addr),
    .ctl_upd      (ctl_upd),
    .ctl_cap_flag (ctl_cap_flag),
    .ctl_wr_flag  (ctl_upd_val[B_PEND]),
    .fd_upd       (fd_upd),
    .fd_cap_flag  (fd_cap_flag),
    .fd_wr_flag   (fd_upd_val[0]),
    .req_ready    (req_ready),
    .pending      (pend),
    .acc_write    (acc_write),
    .acc_size     (acc_size),
    .acc_addr     (acc_addr),
    .acc_done     (acc_done)
  );

  assign acc_pending  = pend;
  assign proc_rst_req = cmd.proc_rst;
  assign per_rst_req  = cmd.per_rst;
  assign dbg_int_req  = cmd.dint;
  assign probe_en     = cmd.probe_en;
  assign probe_trap   = cmd.trap;
  assign scan_tdo     = scan_ctl_sel ? ctl_tdo : (scan_fd_sel ? fd_tdo : 1'b0);

  p_ready_blocked_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    acc_pending |-> !req_ready);
  p_status_unlisted_r12: assert property (@(posedge clk) disable iff (!rst_int_n)
    (scan_ctl_sel && scan_capture) |=> (ctl_upd_val[28:23] == '0 && ctl_upd_val[17] == 1'b0));
endmodule

// File: tb/dbg_ctl_reg_test.sv
module dbg_ctl_reg_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [31:0] req_addr = 32'd0;
  logic        req_ready, acc_pending, acc_write, acc_done;
  logic [1:0]  acc_size;
  logic [31:0] acc_addr;
  logic        cpu_debug_mode = 1'b0, cpu_low_power = 1'b0, cpu_clk_stopped = 1'b0;
  logic        sys_reset_event = 1'b0, dbg_int_ack = 1'b0;
  logic        proc_rst_req, per_rst_req, dbg_int_req, probe_en, probe_trap;
  logic        scan_ctl_sel = 1'b0, scan_fd_sel = 1'b0;
  logic        scan_capture = 1'b0, scan_shift = 1'b0, scan_update = 1'b0, scan_tdi = 1'b0;
  logic        scan_tdo;

  int checks = 0;
  int errors = 0;
  logic done_seen;

  always #10 clk = ~clk;

  dbg_ctl_reg #(.ADDR_W(32)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_size(req_size), .req_addr(req_addr),
    .req_ready(req_ready), .acc_pending(acc_pending), .acc_write(acc_write),
    .acc_size(acc_size), .acc_addr(acc_addr), .acc_done(acc_done),
    .cpu_debug_mode(cpu_debug_mode), .cpu_low_power(cpu_low_power),
    .cpu_clk_stopped(cpu_clk_stopped), .sys_reset_event(sys_reset_event),
    .dbg_int_ack(dbg_int_ack), .proc_rst_req(proc_rst_req), .per_rst_req(per_rst_req),
    .dbg_int_req(dbg_int_req), .probe_en(probe_en), .probe_trap(probe_trap),
    .scan_ctl_sel(scan_ctl_sel), .scan_fd_sel(scan_fd_sel), .scan_capture(scan_capture),
    .scan_shift(scan_shift), .scan_update(scan_update), .scan_tdi(scan_tdi),
    .scan_tdo(scan_tdo)
  );

  // written word and expected {per_rst, proc_rst, probe_en, trap} after it
  localparam logic [31:0] VEC_WR  [4] = '{32'h8001_0000, 32'h8010_4000, 32'h8001_8000, 32'h8000_0000};
  localparam logic [3:0]  VEC_EXP [4] = '{4'b0100, 4'b1001, 4'b0110, 4'b0000};

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic scan_ctrl(input logic [31:0] wr, input bit mid_req, output logic [31:0] rd);
    @(negedge clk);
    scan_ctl_sel = 1'b1;
    scan_capture = 1'b1;
    @(negedge clk);
    scan_capture = 1'b0;
    scan_shift   = 1'b1;
    for (int i = 0; i < 32; i++) begin
      rd[i]    = scan_tdo;
      scan_tdi = wr[i];
      if (mid_req && i == 5) req_valid = 1'b1;
      if (mid_req && i == 6) req_valid = 1'b0;
      @(negedge clk);
    end
    scan_shift  = 1'b0;
    scan_update = 1'b1;
    @(negedge clk);
    scan_update  = 1'b0;
    scan_ctl_sel = 1'b0;
    done_seen    = acc_done;
  endtask

  task automatic scan_fd(input logic wbit, output logic rbit);
    @(negedge clk);
    scan_fd_sel  = 1'b1;
    scan_capture = 1'b1;
    @(negedge clk);
    scan_capture = 1'b0;
    scan_shift   = 1'b1;
    rbit         = scan_tdo;
    scan_tdi     = wbit;
    @(negedge clk);
    scan_shift  = 1'b0;
    scan_update = 1'b1;
    @(negedge clk);
    scan_update = 1'b0;
    scan_fd_sel = 1'b0;
    done_seen   = acc_done;
  endtask

  task automatic offer(input logic w, input logic [1:0] sz, input logic [31:0] a);
    @(negedge clk);
    req_write = w; req_size = sz; req_addr = a; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'd0, 32'd1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic        fbit;
    logic [3:0]  prev;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state at the pins
    check({proc_rst_req, per_rst_req, dbg_int_req, probe_en, probe_trap, acc_pending, acc_done} == 7'd0,
          "R1 outputs", {25'd0, proc_rst_req, per_rst_req, dbg_int_req, probe_en, probe_trap, acc_pending, acc_done}, 32'd0);

    // table walk: R2 ordering, R8 and R10 outputs and readback
    prev = 4'b0000;
    for (int v = 0; v < 4; v++) begin
      scan_ctrl(VEC_WR[v], 1'b0, rd);
      if (v == 0) check(rd == 32'h8000_0000, "R1 R2 first capture", rd, 32'h8000_0000);
      check({rd[20], rd[16], rd[15], rd[14]} == prev, "R8 R10 readback",
            {28'd0, rd[20], rd[16], rd[15], rd[14]}, {28'd0, prev});
      check({per_rst_req, proc_rst_req, probe_en, probe_trap} == VEC_EXP[v], "R8 R10 pins",
            {28'd0, per_rst_req, proc_rst_req, probe_en, probe_trap}, {28'd0, VEC_EXP[v]});
      prev = VEC_EXP[v];
    end

    // R3: servicing disabled blocks requests
    check(req_ready == 1'b0, "R3 ready while disabled", {31'd0, req_ready}, 32'd0);
    offer(1'b1, 2'd2, 32'h0BAD_0000);
    check(acc_pending == 1'b0, "R3 no accept while disabled", {31'd0, acc_pending}, 32'd0);
    scan_ctrl(32'h8000_8000, 1'b0, rd);
    check(rd[18] == 1'b0, "R3 bit18 idle", {31'd0, rd[18]}, 32'd0);
    check(req_ready == 1'b1, "R3 ready when enabled", {31'd0, req_ready}, 32'd1);

    // R4: word store request
    offer(1'b1, 2'd2, 32'h1234_5678);
    check(acc_pending && acc_write && acc_size == 2'd2 && acc_addr == 32'h1234_5678,
          "R4 latched request", acc_addr, 32'h1234_5678);
    check(req_ready == 1'b0, "R3 ready while pending", {31'd0, req_ready}, 32'd0);
    offer(1'b0, 2'd0, 32'hDEAD_BEEF);
    check(acc_addr == 32'h1234_5678 && acc_write, "R3 second request ignored", acc_addr, 32'h1234_5678);
    scan_ctrl(32'h8004_8000, 1'b0, rd);
    check(rd == 32'hC00C_8000, "R4 pending readback", rd, 32'hC00C_8000);
    check(acc_pending == 1'b1 && done_seen == 1'b0, "R5 write one keeps pending",
          {30'd0, acc_pending, done_seen}, 32'd2);

    // R5: completion
    scan_ctrl(32'h8000_8000, 1'b0, rd);
    check(done_seen == 1'b1 && acc_pending == 1'b0, "R5 completion",
          {30'd0, acc_pending, done_seen}, 32'd1);
    @(negedge clk);
    check(acc_done == 1'b0, "R5 single pulse", {31'd0, acc_done}, 32'd0);

    // R6: request arriving after capture is not completed by that scan
    req_write = 1'b0; req_size = 2'd1; req_addr = 32'hA5A5_0000;
    scan_ctrl(32'h8000_8000, 1'b1, rd);
    check(acc_pending == 1'b1 && done_seen == 1'b0, "R6 stale capture",
          {30'd0, acc_pending, done_seen}, 32'd2);
    scan_ctrl(32'h8004_8000, 1'b0, rd);
    check(rd == 32'hA004_8000, "R4 load readback", rd, 32'hA004_8000);

    // R13: fast-data flag
    scan_fd(1'b0, fbit);
    check(fbit == 1'b1, "R13 success flag", {31'd0, fbit}, 32'd1);
    check(done_seen == 1'b1 && acc_pending == 1'b0, "R13 completion",
          {30'd0, acc_pending, done_seen}, 32'd1);
    scan_fd(1'b0, fbit);
    check(fbit == 1'b0 && done_seen == 1'b0, "R13 failure flag",
          {30'd0, fbit, done_seen}, 32'd0);

    // R7: reset-occurred bit
    scan_ctrl(32'h0000_8000, 1'b0, rd);
    scan_ctrl(32'h8000_8000, 1'b0, rd);
    check(rd[31] == 1'b0, "R7 cleared by zero", {31'd0, rd[31]}, 32'd0);
    scan_ctrl(32'h8000_8000, 1'b0, rd);
    check(rd[31] == 1'b0, "R7 one has no effect", {31'd0, rd[31]}, 32'd0);
    @(negedge clk);
    sys_reset_event = 1'b1;
    @(negedge clk);
    sys_reset_event = 1'b0;
    scan_ctrl(32'h8000_8000, 1'b0, rd);
    check(rd[31] == 1'b1, "R7 set by event", {31'd0, rd[31]}, 32'd1);

    // R9: debug interrupt request
    scan_ctrl(32'h8000_9000, 1'b0, rd);
    check(dbg_int_req == 1'b1, "R9 raise", {31'd0, dbg_int_req}, 32'd1);
    scan_ctrl(32'h8000_8000, 1'b0, rd);
    check(dbg_int_req == 1'b1 && rd[12] == 1'b1, "R9 zero no effect",
          {30'd0, dbg_int_req, rd[12]}, 32'd3);
    @(negedge clk);
    dbg_int_ack = 1'b1;
    @(negedge clk);
    dbg_int_ack = 1'b0;
    check(dbg_int_req == 1'b0, "R9 ack clears", {31'd0, dbg_int_req}, 32'd0);

    // R11 R12: status and unlisted bits
    cpu_debug_mode = 1'b1; cpu_low_power = 1'b1; cpu_clk_stopped = 1'b1;
    scan_ctrl(32'hFFFF_FFFF, 1'b0, rd);
    check(proc_rst_req && per_rst_req, "R8 all-ones write", {30'd0, proc_rst_req, per_rst_req}, 32'd3);
    scan_ctrl(32'h8000_8000, 1'b0, rd);
    check(rd == 32'h8071_D008, "R11 R12 status and unlisted", rd, 32'h8071_D008);
    check(acc_pending == 1'b0, "R12 write of bit18 idle", {31'd0, acc_pending}, 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule